// File: doc/BRIEF.md
# Wavetable Sample Memory Access Arbiter

This block holds the sample table of a wavetable audio voice: sixteen bytes, each packing two 4-bit samples, thirty-two samples in all. The playback engine and the CPU share it. While the voice is idle, the CPU reads and writes any byte by its address. While the voice plays, a 5-bit playback position picks which sample goes to the mixer, and CPU accesses are steered onto the byte under that position.

A mode input chooses between two behaviours while the voice plays. In strict mode, the CPU reaches the table only during a one-clock window that follows each sample fetch. Outside that window a read returns 0xFF and a write is lost. In relaxed mode, reads always return the byte being played, and writes still land on the byte the CPU addressed.

CPU reads are registered: the read data updates on the clock edge where the read strobe is high and holds otherwise. The sample output follows the playback position and the table with no extra delay.

Top module: `wave_ram_arbiter`

## Requirements
- R1: After a synchronous active-high reset, every table byte is 0x00, the playback position is 0, the read data is 0x00 and the sample output is 0.
- R2: With `playing` low, a read loads the byte at `cpu_addr` into `cpu_rdata` at the clock edge where `cpu_rd` is high; with `cpu_rd` low, `cpu_rdata` holds its value.
- R3: With `playing` low, a write stores `cpu_wdata` into the byte at `cpu_addr`, whatever the mode.
- R4: The playback position is held at 0 while `playing` is low. While `playing` is high, each `adv_tick` adds one, and the position wraps from 31 to 0.
- R5: `sample_out` is taken from byte (position / 2): the high nibble (bits 7:4) when the position is even, the low nibble (bits 3:0) when it is odd.
- R6: The access window is open for exactly the one clock that follows a clock with `fetch_pulse` high, and is closed at every other time.
- R7: With `strict_mode` high and `playing` high, a read outside the window returns 0xFF.
- R8: With `strict_mode` high and `playing` high, a read inside the window returns byte (position / 2), whatever `cpu_addr` is.
- R9: With `strict_mode` high and `playing` high, a write outside the window changes no byte. A write inside the window stores into byte (position / 2), whatever `cpu_addr` is.
- R10: With `strict_mode` low and `playing` high, a read returns byte (position / 2), whatever `cpu_addr` is.
- R11: With `strict_mode` low and `playing` high, a write stores into the byte at `cpu_addr`.
- R12: A read and a write in the same clock return the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 4 | CPU byte address into the table |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| playing | input | 1 | Voice is playing |
| strict_mode | input | 1 | 1 = windowed access while playing, 0 = relaxed access |
| adv_tick | input | 1 | Advance the playback position by one sample |
| fetch_pulse | input | 1 | Sample fetch; opens the access window on the next clock |
| cpu_rdata | output | 8 | Registered CPU read data |
| sample_out | output | 4 | Current 4-bit sample for playback |

## Verification
The bench walks the position through a full wrap while it watches the nibble order. A design that swapped the nibbles, or that failed to wrap at 31, would play the table in the wrong order. In strict mode it reads in the clock right after a fetch, then one clock later, and writes with a CPU address far from the played byte. An off-by-one window would return 0xFF where data is due, a write that leaks past the window would corrupt the table, and a write that went to the CPU address would change the wrong byte. It also mixes a read and a write to one byte in the same clock, and it checks that relaxed writes keep their CPU address while playing, which catches a design that redirects them the way it redirects reads.

// File: rtl/wave_pkg.sv
package wave_pkg;

    localparam int unsigned WAVE_BYTES = 16;
    localparam int unsigned WAVE_DW    = 8;
    localparam int unsigned WAVE_SW    = 4;
    localparam int unsigned WAVE_AW    = $clog2(WAVE_BYTES);
    localparam int unsigned WAVE_POSW  = $clog2(WAVE_BYTES * (WAVE_DW / WAVE_SW));

    typedef struct packed {
        logic               hit;
        logic [WAVE_AW-1:0] idx;
        logic [WAVE_DW-1:0] data;
    } wr_req_t;

    typedef enum logic [1:0] {
        RD_DIRECT  = 2'd0,
        RD_PLAYED  = 2'd1,
        RD_BLOCKED = 2'd2
    } rd_src_e;

    // byte index under a playback position (two samples per byte)
    function automatic logic [WAVE_AW-1:0] pos_to_idx(input logic [WAVE_POSW-1:0] pos);
        return pos[WAVE_POSW-1:1];
    endfunction

    // even position -> upper nibble, odd position -> lower nibble
    function automatic logic [WAVE_SW-1:0] pick_nibble(input logic [WAVE_DW-1:0] b,
                                                       input logic odd);
        return odd ? b[WAVE_SW-1:0] : b[WAVE_DW-1:WAVE_SW];
    endfunction

endpackage

// File: rtl/wave_pos_ctr.sv
module wave_pos_ctr
    import wave_pkg::*;
#(
    parameter int unsigned POSW = WAVE_POSW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            playing,
    input  logic            adv_tick,
    input  logic            fetch_pulse,
    output logic [POSW-1:0] pos,
    output logic            win
);

    localparam logic [POSW-1:0] POS_LAST = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
            win <= 1'b0;
        end else begin
            win <= fetch_pulse;
            if (!playing)
                pos <= '0;
            else if (adv_tick)
                pos <= pos + 1'b1;
        end
    end

    p_pos_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        playing && adv_tick && pos == POS_LAST |=> pos == '0);

    p_pos_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !playing |=> pos == '0);

    p_pos_step_r4: assert property (@(posedge clk) disable iff (rst)
        playing && adv_tick && pos != POS_LAST |=> pos == $past(pos) + 1'b1);

    p_win_open_r6: assert property (@(posedge clk) disable iff (rst)
        fetch_pulse |=> win);

    p_win_closed_r6: assert property (@(posedge clk) disable iff (rst)
        !fetch_pulse |=> !win);

endmodule

// File: rtl/wave_access_mux.sv
module wave_access_mux
    import wave_pkg::*;
#(
    parameter int unsigned AW   = WAVE_AW,
    parameter int unsigned DW   = WAVE_DW,
    parameter int unsigned POSW = WAVE_POSW
) (
    input  logic            playing,
    input  logic            strict_mode,
    input  logic            win,
    input  logic [AW-1:0]   cpu_addr,
    input  logic            cpu_wr,
    input  logic [DW-1:0]   cpu_wdata,
    input  logic [POSW-1:0] pos,
    output wr_req_t         wreq,
    output rd_src_e         rd_src,
    output logic [AW-1:0]   rd_idx,
    output logic [AW-1:0]   play_idx
);

    always_comb begin
        play_idx   = pos_to_idx(pos);
        wreq.data  = cpu_wdata;
        wreq.idx   = cpu_addr;
        wreq.hit   = cpu_wr;
        rd_src     = RD_DIRECT;
        rd_idx     = cpu_addr;
        if (playing) begin
            rd_idx = play_idx;
            if (strict_mode) begin
                rd_src   = win ? RD_PLAYED : RD_BLOCKED;
                wreq.idx = play_idx;
                wreq.hit = cpu_wr && win;
            end else begin
                rd_src = RD_PLAYED;
            end
        end
    end

endmodule

// File: rtl/wave_store.sv
module wave_store
    import wave_pkg::*;
#(
    parameter int unsigned NBYTES = WAVE_BYTES,
    parameter int unsigned DW     = WAVE_DW,
    parameter int unsigned SW     = WAVE_SW,
    localparam int unsigned AW    = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       wreq,
    input  logic [AW-1:0] rd_idx,
    input  logic [AW-1:0] play_idx,
    input  logic          play_odd,
    output logic [DW-1:0] rd_byte,
    output logic [SW-1:0] sample
);

    logic [NBYTES-1:0][DW-1:0] mem;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (wreq.hit && wreq.idx == AW'(g))
                mem[g] <= wreq.data;
        end
    end

    assign rd_byte = mem[rd_idx];
    assign sample  = pick_nibble(mem[play_idx], play_odd);

    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        wreq.hit |=> mem[$past(wreq.idx)] == $past(wreq.data));

    p_no_write_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !wreq.hit |=> $stable(mem));

endmodule

// File: rtl/wave_ram_arbiter.sv
module wave_ram_arbiter
    import wave_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WAVE_AW-1:0]   cpu_addr,
    input  logic                 cpu_wr,
    input  logic                 cpu_rd,
    input  logic [WAVE_DW-1:0]   cpu_wdata,
    input  logic                 playing,
    input  logic                 strict_mode,
    input  logic                 adv_tick,
    input  logic                 fetch_pulse,
    output logic [WAVE_DW-1:0]   cpu_rdata,
    output logic [WAVE_SW-1:0]   sample_out
);

    logic [WAVE_POSW-1:0] pos;
    logic                 win;
    wr_req_t              wreq;
    rd_src_e              rd_src;
    logic [WAVE_AW-1:0]   rd_idx;
    logic [WAVE_AW-1:0]   play_idx;
    logic [WAVE_DW-1:0]   rd_byte;

    wave_pos_ctr #(.POSW(WAVE_POSW)) u_pos (
        .clk(clk), .rst(rst), .playing(playing), .adv_tick(adv_tick),
        .fetch_pulse(fetch_pulse), .pos(pos), .win(win)
    );

    wave_access_mux #(.AW(WAVE_AW), .DW(WAVE_DW), .POSW(WAVE_POSW)) u_mux (
        .playing(playing), .strict_mode(strict_mode), .win(win),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .pos(pos),
        .wreq(wreq), .rd_src(rd_src), .rd_idx(rd_idx), .play_idx(play_idx)
    );

    wave_store #(.NBYTES(WAVE_BYTES), .DW(WAVE_DW), .SW(WAVE_SW)) u_store (
        .clk(clk), .rst(rst), .wreq(wreq), .rd_idx(rd_idx), .play_idx(play_idx),
        .play_odd(pos[0]), .rd_byte(rd_byte), .sample(sample_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cpu_rdata <= '0;
        else if (cpu_rd)
            cpu_rdata <= (rd_src == RD_BLOCKED) ? '1 : rd_byte;
    end

    p_blocked_read_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_rd && playing && strict_mode && !win |=> cpu_rdata == '1);

    p_blocked_write_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_wr && playing && strict_mode && !win |=> $stable(u_store.mem));

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd |=> $stable(cpu_rdata));

    p_idle_read_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_rd && !playing |=> cpu_rdata == $past(u_store.mem[cpu_addr]));

endmodule

// File: tb/wave_ram_arbiter_test.sv
module wave_ram_arbiter_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] cpu_addr;
    logic       cpu_wr, cpu_rd;
    logic [7:0] cpu_wdata;
    logic       playing, strict_mode, adv_tick, fetch_pulse;
    logic [7:0] cpu_rdata;
    logic [3:0] sample_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // bench model
    logic [7:0] m_mem [16];
    logic [4:0] m_pos;
    logic       m_win;
    logic [7:0] m_rdata;

    always #5 clk = ~clk;

    wave_ram_arbiter uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .playing(playing), .strict_mode(strict_mode),
        .adv_tick(adv_tick), .fetch_pulse(fetch_pulse),
        .cpu_rdata(cpu_rdata), .sample_out(sample_out)
    );

    function automatic logic [3:0] exp_sample();
        logic [7:0] b = m_mem[m_pos[4:1]];
        return m_pos[0] ? b[3:0] : b[7:4];
    endfunction

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic rd, input logic [3:0] a,
                        input logic [7:0] d, input logic pl, input logic cm,
                        input logic tk, input logic fp, input string tag);
        string rtag;
        cpu_wr = wr; cpu_rd = rd; cpu_addr = a; cpu_wdata = d;
        playing = pl; strict_mode = cm; adv_tick = tk; fetch_pulse = fp;
        if (!pl)               rtag = "R2";
        else if (cm && !m_win) rtag = "R7";
        else if (cm)           rtag = "R8";
        else                   rtag = "R10";
        if (tag != "") rtag = tag;
        // model: read sees old contents (R12)
        if (rd) begin
            if (!pl)               m_rdata = m_mem[a];
            else if (cm && !m_win) m_rdata = 8'hFF;
            else                   m_rdata = m_mem[m_pos[4:1]];
        end
        if (wr) begin
            if (!pl || !cm)  m_mem[a] = d;
            else if (m_win)  m_mem[m_pos[4:1]] = d;
        end
        if (!pl)     m_pos = 5'd0;
        else if (tk) m_pos = m_pos + 5'd1;
        m_win = fp;
        @(posedge clk);
        @(negedge clk);
        check8(cpu_rdata, m_rdata, {rtag, " rdata"});
        check8({4'h0, sample_out}, {4'h0, exp_sample()}, (tag != "") ? {tag, " sample"} : "R5 sample");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5A17));
        cpu_wr = 0; cpu_rd = 0; cpu_addr = 0; cpu_wdata = 0;
        playing = 0; strict_mode = 0; adv_tick = 0; fetch_pulse = 0;
        for (int i = 0; i < 16; i++) m_mem[i] = 8'h00;
        m_pos = 0; m_win = 0; m_rdata = 8'h00;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        check8(cpu_rdata, 8'h00, "R1 rdata after reset");
        check8({4'h0, sample_out}, 8'h00, "R1 sample after reset");
        step(0, 1, 4'd9, 8'h00, 0, 0, 0, 0, "R1");

        // R3 idle writes in both modes, R2 readback
        for (int i = 0; i < 16; i++)
            step(1, 0, 4'(i), {4'(i), ~4'(i)}, 0, i[0], 1, 0, "R3");
        for (int i = 15; i >= 0; i--)
            step(0, 1, 4'(i), 8'h00, 0, 0, 0, 0, "R2");
        step(0, 0, 4'd2, 8'h00, 0, 0, 0, 0, "R2 hold");

        // R12 same-cycle read and write
        step(1, 1, 4'd6, 8'hC3, 0, 0, 0, 0, "R12");
        step(0, 1, 4'd6, 8'h00, 0, 0, 0, 0, "R12");

        // R4/R5 relaxed playback across full wrap
        for (int i = 0; i < 34; i++)
            step(0, 0, 4'd0, 8'h00, 1, 0, 1, 0, "R4");
        // R10 reads follow position; R11 writes keep cpu address
        step(0, 1, 4'd15, 8'h00, 1, 0, 0, 0, "R10");
        step(1, 0, 4'd12, 8'h5E, 1, 0, 0, 0, "R11");
        step(0, 1, 4'd12, 8'h00, 0, 0, 0, 0, "R11");
        step(0, 1, 4'd0, 8'h00, 0, 0, 0, 0, "R11");

        // strict mode while playing
        step(0, 0, 4'd0, 8'h00, 1, 1, 1, 0, "R4");
        step(0, 0, 4'd0, 8'h00, 1, 1, 1, 0, "R4");
        step(0, 0, 4'd0, 8'h00, 1, 1, 1, 0, "R4");
        step(0, 1, 4'd7, 8'h00, 1, 1, 0, 0, "R7");
        step(0, 0, 4'd7, 8'h00, 1, 1, 0, 1, "R6");
        step(0, 1, 4'd11, 8'h00, 1, 1, 0, 0, "R8");
        step(0, 1, 4'd11, 8'h00, 1, 1, 0, 0, "R6");
        step(1, 0, 4'd14, 8'hA7, 1, 1, 0, 0, "R9");
        step(0, 0, 4'd14, 8'h00, 1, 1, 0, 1, "R6");
        step(1, 0, 4'd14, 8'h3B, 1, 1, 0, 0, "R9");
        step(0, 1, 4'd14, 8'h00, 0, 1, 0, 0, "R9");
        step(0, 1, 4'd1, 8'h00, 0, 1, 0, 0, "R9");

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic pl = ($urandom_range(0, 99) < 85) ? 1'b1 : playing;
            if ($urandom_range(0, 99) < 3) pl = ~playing;
            step($urandom_range(0, 99) < 30, $urandom_range(0, 99) < 50,
                 4'($urandom_range(0, 15)), 8'($urandom_range(0, 255)),
                 pl, ($urandom_range(0, 99) < 90) ? strict_mode : ~strict_mode,
                 $urandom_range(0, 99) < 40, $urandom_range(0, 99) < 25, "");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule